// File: doc/BRIEF.md
# Pulse-Train Interval Timer

This block times a short burst of digital pulses produced by a charge-to-time converter. Each event produces a train of four pulses. The block counts system clocks from the rising edge of the first pulse to the rising edge of the third pulse. The fourth pulse and any pulses after it are ignored. The pulse line is asynchronous to the system clock, so it is synchronized and edge-detected before the timing logic uses it.

When the surrounding event logic finishes an event, it raises a one-cycle end strobe. The block then always emits exactly one 16-bit word, so the readout can place that word ahead of the event's stop marker. The word is either a result or a failure code. A result word carries the tag nibble 0xD above the 12-bit count. The failure code 0xDFFF is emitted when no third pulse was seen, or when the count reached the reserved value 0xFFF. After every end strobe the timing state is cleared, so the next train starts from nothing.

Top module: `ctc_interval_timer`

## Requirements
- R1: While reset is asserted, and after it is released until the first end strobe, `res_valid` is 0 and `res_word` is 0x0000. A reset also discards any partly received train.
- R2: The reported count equals the number of system clock cycles between the rising edge of the first pulse and the rising edge of the third pulse. The first pulse restarts the count from zero.
- R3: The fourth pulse, and any later pulse before the end strobe, leaves the reported count unchanged.
- R4: A result word has bits [15:12] = 0xD and bits [11:0] = the count.
- R5: If fewer than three pulses arrived before the end strobe, the word is 0xDFFF.
- R6: A count of 4095 (0xFFF) or more yields 0xDFFF. The largest count reported as a result is 4094 (0xFFE).
- R7: Each end strobe produces `res_valid` = 1 for exactly the one cycle after the strobe is sampled. `res_word` is 0x0000 whenever `res_valid` is 0.
- R8: An end strobe clears the timing state. A train that is cut off by the strobe leaves no trace in the next event's word.
- R9: A pulse that stays high for several clocks is counted as one pulse. Its position is taken from its rising edge after the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Asynchronous pulse train from the converter |
| evt_end | input | 1 | One-cycle end-of-event strobe, synchronous to clk |
| res_word | output | 16 | Result or failure word, nonzero only while valid |
| res_valid | output | 1 | High for one cycle after each end strobe |

## Verification
The assertions assume that `evt_end` is a single-cycle strobe and that two strobes are never on adjacent cycles. They also assume that every pulse is high for at least one clock and low for at least one clock between pulses, so the synchronizer sees each edge. The stimulus drives pulses on the falling clock edge and keeps pulse spacing at two cycles or more. It waits several cycles after the last pulse before strobing, so the synchronizer pipeline has drained. Each strobe is followed by an idle gap.

// File: rtl/ctc_timer_pkg.sv
package ctc_timer_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 12;
  localparam int TAG_W  = WORD_W - CNT_W;
  localparam logic [TAG_W-1:0] RESULT_TAG   = 4'hD;
  localparam logic [CNT_W-1:0] CNT_RESERVED = '1;
  localparam logic [WORD_W-1:0] FAIL_WORD   = {RESULT_TAG, CNT_RESERVED};

  // Saturating increment: stops at the reserved code.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_RESERVED) ? v : v + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  // Build the outgoing word from the stop flag and the captured count.
  function automatic logic [WORD_W-1:0] pack_result(input logic stopped,
                                                    input logic [CNT_W-1:0] cnt);
    if (stopped && (cnt != CNT_RESERVED)) return {RESULT_TAG, cnt};
    return FAIL_WORD;
  endfunction
endpackage

// File: rtl/ctc_pulse_sync.sv
module ctc_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // stage[0..STAGES-1] synchronize, stage[STAGES] is the edge reference
  logic [STAGES:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= 1'b0;
    else        stage[0] <= din;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= 1'b0;
      else        stage[i] <= stage[i-1];
    end
  end

  assign rise = stage[STAGES-1] & ~stage[STAGES];
endmodule

// File: rtl/ctc_train_tracker.sv
module ctc_train_tracker
  import ctc_timer_pkg::*;
#(
  parameter int PULSES    = 4,
  parameter int START_POS = 1,
  parameter int STOP_POS  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_edge,
  input  logic             clear,
  output logic             start_evt,
  output logic             stop_evt,
  output logic             running,
  output logic             stop_seen,
  output logic [CNT_W-1:0] count_q
);
  localparam int PC_W = $clog2(PULSES + 1);
  localparam logic [PC_W-1:0] START_IDX = PC_W'(START_POS - 1);
  localparam logic [PC_W-1:0] STOP_IDX  = PC_W'(STOP_POS - 1);
  localparam logic [PC_W-1:0] LAST_IDX  = PC_W'(PULSES);

  logic [PC_W-1:0] pcnt;

  assign start_evt = pulse_edge && (pcnt == START_IDX);
  assign stop_evt  = pulse_edge && (pcnt == STOP_IDX) && running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt      <= '0;
      running   <= 1'b0;
      stop_seen <= 1'b0;
      count_q   <= '0;
    end else if (clear) begin
      pcnt      <= '0;
      running   <= 1'b0;
      stop_seen <= 1'b0;
      count_q   <= '0;
    end else begin
      if (pulse_edge && (pcnt != LAST_IDX)) pcnt <= pcnt + 1'b1;
      if (start_evt) begin
        count_q <= '0;
        running <= 1'b1;
      end else if (running) begin
        count_q <= sat_inc(count_q);
        if (stop_evt) begin
          running   <= 1'b0;
          stop_seen <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ctc_result_fmt.sv
module ctc_result_fmt
  import ctc_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_end,
  input  logic              stop_seen,
  input  logic [CNT_W-1:0]  count_q,
  output logic [WORD_W-1:0] res_word,
  output logic              res_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_word  <= '0;
    end else begin
      res_valid <= evt_end;
      res_word  <= evt_end ? pack_result(stop_seen, count_q) : '0;
    end
  end
endmodule

// File: rtl/ctc_interval_timer.sv
module ctc_interval_timer
  import ctc_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PULSES      = 4,
  parameter int START_POS   = 1,
  parameter int STOP_POS    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_in,
  input  logic              evt_end,
  output logic [WORD_W-1:0] res_word,
  output logic              res_valid
);
  logic             pulse_edge;
  logic             start_evt;
  logic             stop_evt;
  logic             running;
  logic             stop_seen;
  logic [CNT_W-1:0] count_q;

  ctc_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pulse_in),
    .rise (pulse_edge)
  );

  ctc_train_tracker #(
    .PULSES(PULSES), .START_POS(START_POS), .STOP_POS(STOP_POS)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_edge(pulse_edge),
    .clear     (evt_end),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .running   (running),
    .stop_seen (stop_seen),
    .count_q   (count_q)
  );

  ctc_result_fmt u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_end  (evt_end),
    .stop_seen(stop_seen),
    .count_q  (count_q),
    .res_word (res_word),
    .res_valid(res_valid)
  );
endmodule

// File: rtl/ctc_interval_chk.sv
module ctc_interval_chk
  import ctc_timer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              evt_end,
  input logic [WORD_W-1:0] res_word,
  input logic              res_valid,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              running,
  input logic              stop_seen,
  input logic [CNT_W-1:0]  count_q
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !evt_end) |=> (count_q == '0 && running)); // R2

  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && !evt_end) |=> $stable(count_q)); // R3

  AST_RESULT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_word[WORD_W-1:CNT_W] == RESULT_TAG)); // R4

  AST_FAIL_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_end && !stop_seen) |=> (res_word == FAIL_WORD)); // R5

  AST_FAIL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_end && count_q == CNT_RESERVED) |=> (res_word == FAIL_WORD)); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_word == '0)); // R7

  AST_SINGLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R7

  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_end |=> (!stop_seen && !running && count_q == '0)); // R8

  AST_STOP_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !evt_end) |=> (stop_seen && !running)); // R2
endmodule

bind ctc_interval_timer ctc_interval_chk u_chk (.*);

// File: tb/tb_ctc_interval_timer.sv
module tb_ctc_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulse_in = 1'b0;
  logic        evt_end = 1'b0;
  logic [15:0] res_word;
  logic        res_valid;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ctc_interval_timer dut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .evt_end(evt_end),
    .res_word(res_word), .res_valid(res_valid)
  );

  localparam int NV = 11;
  localparam int V_N [NV]  = '{4, 4, 4,    4,    4,    4,    3,  2,  1, 0, 4};
  localparam int V_G0[NV]  = '{10, 2, 100, 2048, 2048, 3000, 20, 20, 0, 0, 5};
  localparam int V_G1[NV]  = '{15, 2, 200, 2046, 2047, 3000, 30, 0,  0, 0, 6};
  localparam int V_G2[NV]  = '{7,  2, 3,   5,    5,    2,    0,  0,  0, 0, 500};
  localparam logic [15:0] V_EXP[NV] = '{16'hD019, 16'hD004, 16'hD12C, 16'hDFFE,
    16'hDFFF, 16'hDFFF, 16'hD032, 16'hDFFF, 16'hDFFF, 16'hDFFF, 16'hD00B};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic one_pulse(input int w, input int gap);
    pulse_in = 1'b1;
    repeat (w) @(negedge clk);
    pulse_in = 1'b0;
    repeat (gap - w) @(negedge clk);
  endtask

  task automatic send_train(input int n, input int g0, input int g1, input int g2);
    int g [3];
    g[0] = g0; g[1] = g1; g[2] = g2;
    for (int i = 0; i < n; i++) one_pulse(1, (i < 3 && g[i] > 1) ? g[i] : 3);
  endtask

  task automatic send_uniform(input int n, input int w, input int gap);
    for (int i = 0; i < n; i++) one_pulse(w, gap);
  endtask

  // strobe end, check the word in the valid cycle, then the idle cycle after
  task automatic end_event(input string req, input logic [15:0] exp);
    repeat (5) @(negedge clk);
    evt_end = 1'b1;
    @(negedge clk);
    evt_end = 1'b0;
    check({req, " valid"}, {15'd0, res_valid}, 16'd1);
    check(req, res_word, exp);
    @(negedge clk);
    check("R7 valid drops", {15'd0, res_valid}, 16'd0);
    check("R7 idle word", res_word, 16'h0000);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {15'd0, res_valid}, 16'd0);
    check("R1 reset word", res_word, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", {15'd0, res_valid}, 16'd0);

    // table: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      send_train(V_N[v], V_G0[v], V_G1[v], V_G2[v]);
      end_event($sformatf("R2/R4/R5/R6 vector %0d", v), V_EXP[v]);
    end

    // R8: strobe cuts a train, next train measured fresh
    send_train(2, 9, 0, 0);
    end_event("R8 cut train", 16'hDFFF);
    send_train(4, 12, 13, 4);
    end_event("R8 fresh train", 16'hD019);

    // R8: back-to-back events without pulses
    end_event("R8 empty event", 16'hDFFF);

    // R3: six pulses, only first and third matter (gap 7 -> 14)
    send_uniform(6, 1, 7);
    end_event("R3 extra pulses", 16'hD00E);

    // R9: wide pulses counted once by their rising edge (spacing 8 -> 16)
    send_uniform(4, 5, 8);
    end_event("R9 wide pulses", 16'hD010);

    // R1: reset mid-train discards the partial train
    send_uniform(3, 1, 4);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 valid in reset", {15'd0, res_valid}, 16'd0);
    rst_n = 1'b1;
    end_event("R1 reset discards", 16'hDFFF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule